// File: doc/BRIEF.md
# Sector Write Protection Checker

This block guards program and erase operations on a 4 KB non-volatile array. It holds an 8-bit protection register and judges every command the sequencer is about to launch. The register has a global open bit, a range-off bit, a 3-bit region size and three general-purpose flag bits. The block takes the protection byte stored in the array as an input and loads the register from it while reset is held.

Writes to the register follow one-way rules in normal operation. The open and range-off bits can only move toward the protected value. The size field locks as soon as range protection is active. A debug input lifts these rules for every writable bit. The protected region sits at the top of the array and grows downward in 64-byte steps.

The violation flag is combinational in the command code, the target address and the current register contents. The sequencer can therefore sample it in the same cycle it launches a command.

Top module: `sector_guard`

## Requirements
- R1: While reset is low, `prot_q` equals `boot_prot`. The byte layout is: bit 7 open, bits 6:4 flags, bit 3 range-off, bits 2:0 size.
- R2: When the open bit is 0, `violation` is 1 for program (0x20), sector erase (0x40) and sector modify (0x60) at every address.
- R3: When open is 1 and range-off is 1, `violation` is 0 for program, sector erase and sector modify at every address.
- R4: When open is 1 and range-off is 0, a program, sector erase or sector modify raises `violation` exactly when address ≥ 4096 − 64·(size+1). For example, size 0 covers 0xFC0–0xFFF and size 7 covers 0xE00–0xFFF.
- R5: In normal mode (`dbg_mode`=0), a write clears the open bit or the range-off bit when its data bit is 0. A data bit of 1 leaves that bit unchanged.
- R6: In normal mode, a write loads the size field only if range-off was 1 before that write. Otherwise the size field keeps its value.
- R7: Flag bits 6:4 keep their reset-loaded value in every mode, whatever is written.
- R8: When `dbg_mode`=1, a write loads the open bit, the range-off bit and the size field directly from the write data.
- R9: A mass erase (0x41) raises `violation` unless both open and range-off are 1.
- R10: Erase-verify (0x05) and every code not named above never raise `violation`.
- R11: `violation` follows the register in the same cycle that a write takes effect, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads the register from `boot_prot` |
| boot_prot | input | 8 | Protection byte read from the array |
| dbg_mode | input | 1 | Lifts the one-way write rules |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_q | output | 8 | Current register contents |
| cmd_code | input | 8 | Command about to be launched |
| cmd_addr | input | 12 | Byte address targeted by the command |
| violation | output | 1 | Protection violation for the presented command |

## Verification
The hardest state to reach from the ports is active range protection for each of the eight sizes. Once range-off is cleared in normal mode, the size field is frozen and range-off cannot be set again. Because of this, a single run cannot step through the sizes with writes alone. The stimulus revisits each size through a fresh reset with a new boot byte, and in other places through debug-mode writes. For each size it probes the addresses on both sides of the region's lower bound, then tries to undo the lock and checks that the attempt has no effect.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [7:0] {
    CMD_VERIFY = 8'h05,
    CMD_PROG   = 8'h20,
    CMD_SERASE = 8'h40,
    CMD_MERASE = 8'h41,
    CMD_SMOD   = 8'h60
  } cmd_e;

  typedef struct packed {
    logic       open;
    logic [2:0] flags;
    logic       range_off;
    logic [2:0] size;
  } prot_t;

  // lowest protected byte address for size code n
  function automatic int unsigned region_floor(input int unsigned addr_w,
                                               input int unsigned step,
                                               input int unsigned n);
    return (32'd1 << addr_w) - step * (n + 1);
  endfunction

endpackage

// File: rtl/prot_reg_file.sv
module prot_reg_file (
  input  logic            clk,
  input  logic            rst_n,
  input  prot_pkg::prot_t boot,
  input  logic            dbg_mode,
  input  logic            wr_en,
  input  prot_pkg::prot_t wr_data,
  output prot_pkg::prot_t q
);
  import prot_pkg::*;

  prot_t nxt;
  logic  size_frozen;
  logic  open_next;
  logic  off_next;

  assign size_frozen = !dbg_mode && !q.range_off;
  assign open_next   = dbg_mode ? wr_data.open      : (q.open & wr_data.open);
  assign off_next    = dbg_mode ? wr_data.range_off : (q.range_off & wr_data.range_off);

  always_comb begin
    nxt           = q;
    nxt.open      = open_next;
    nxt.range_off = off_next;
    if (!size_frozen) nxt.size = wr_data.size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= boot;
    else if (wr_en) q <= nxt;
  end

  // R5
  open_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode |=> !$rose(q.open));
  // R5
  off_one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_mode |=> !$rose(q.range_off));
  // R6
  size_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode && !q.range_off) |=> $stable(q.size));
  // R7
  flags_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(q.flags));

endmodule

// File: rtl/region_decode.sv
module region_decode #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned STEP_BYTES = 64,
  parameter int unsigned SIZE_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              in_region
);
  localparam int unsigned N_SIZES = 1 << SIZE_W;

  logic [N_SIZES-1:0] above_floor;

  for (genvar i = 0; i < N_SIZES; i++) begin : g_floor
    localparam int unsigned FLOOR_I = prot_pkg::region_floor(ADDR_W, STEP_BYTES, i);
    localparam logic [ADDR_W:0] FLOOR = FLOOR_I[ADDR_W:0];
    assign above_floor[i] = ({1'b0, addr} >= FLOOR);
  end

  assign in_region = above_floor[size];

endmodule

// File: rtl/viol_eval.sv
module viol_eval (
  input  logic [7:0] cmd,
  input  logic       open,
  input  logic       range_off,
  input  logic       in_region,
  output logic       violation
);
  import prot_pkg::*;

  logic target_locked;
  assign target_locked = !open || (!range_off && in_region);

  always_comb begin
    case (cmd)
      CMD_PROG, CMD_SERASE, CMD_SMOD: violation = target_locked;
      CMD_MERASE:                     violation = !(open && range_off);
      default:                        violation = 1'b0;
    endcase
  end

endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned STEP_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        boot_prot,
  input  logic              dbg_mode,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        prot_q,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              violation
);
  import prot_pkg::*;

  localparam int unsigned SIZE_W = 3;

  prot_t reg_q;
  logic  addr_in_region;

  prot_reg_file u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot     (prot_t'(boot_prot)),
    .dbg_mode (dbg_mode),
    .wr_en    (wr_en),
    .wr_data  (prot_t'(wr_data)),
    .q        (reg_q)
  );

  region_decode #(.ADDR_W(ADDR_W), .STEP_BYTES(STEP_BYTES), .SIZE_W(SIZE_W)) u_dec (
    .addr      (cmd_addr),
    .size      (reg_q.size),
    .in_region (addr_in_region)
  );

  viol_eval u_eval (
    .cmd       (cmd_code),
    .open      (reg_q.open),
    .range_off (reg_q.range_off),
    .in_region (addr_in_region),
    .violation (violation)
  );

  assign prot_q = reg_q;

  // R2
  closed_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_q[7] && cmd_code == CMD_PROG) |-> violation);
  // R4
  top_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q[7] && !prot_q[3] && cmd_code == CMD_SMOD && &cmd_addr) |-> violation);
  // R9
  mass_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_MERASE) |-> (violation == !(prot_q[7] && prot_q[3])));
  // R10
  verify_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_VERIFY) |-> !violation);

endmodule

// File: tb/tb_sector_guard.sv
module tb_sector_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  boot_prot = 8'hFF;
  logic        dbg_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  prot_q;
  logic [7:0]  cmd_code = 8'h00;
  logic [11:0] cmd_addr = 12'h000;
  logic        violation;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  int m_open, m_flags, m_off, m_size;

  always #10 clk = ~clk;

  sector_guard dut (
    .clk(clk), .rst_n(rst_n), .boot_prot(boot_prot), .dbg_mode(dbg_mode),
    .wr_en(wr_en), .wr_data(wr_data), .prot_q(prot_q),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .violation(violation)
  );

  function automatic int model_byte();
    return m_open * 128 + m_flags * 16 + m_off * 8 + m_size;
  endfunction

  function automatic int model_viol(input int c, input int a);
    int lowest;
    lowest = 4096 - 64 * (m_size + 1);
    if (c == 'h20 || c == 'h40 || c == 'h60) begin
      if (m_open == 0) return 1;
      if (m_off == 1) return 0;
      return (a >= lowest) ? 1 : 0;
    end
    if (c == 'h41) return (m_open == 1 && m_off == 1) ? 0 : 1;
    return 0;
  endfunction

  function automatic string viol_tag(input int c);
    if (c == 'h41) return "R9";
    if (!(c == 'h20 || c == 'h40 || c == 'h60)) return "R10";
    if (m_open == 0) return "R2";
    if (m_off == 1) return "R3";
    return "R4";
  endfunction

  task automatic compare();
    int eb, ev;
    eb = model_byte();
    ev = model_viol(int'(cmd_code), int'(cmd_addr));
    n_chk++;
    if (int'(prot_q) != eb) begin
      n_bad++;
      $display("FAIL R5 R6 R7 R8 register: actual %02h expected %02h", prot_q, eb[7:0]);
    end
    n_chk++;
    if (int'(violation) != ev) begin
      n_bad++;
      $display("FAIL %s R11 violation cmd %02h addr %03h: actual %0d expected %0d",
               viol_tag(int'(cmd_code)), cmd_code, cmd_addr, violation, ev);
    end
  endtask

  // one clock: drive at negedge, compare mid-low-phase, update model at posedge
  task automatic apply(input logic w, input logic [7:0] d, input logic [7:0] c,
                       input logic [11:0] a, input logic g);
    wr_en = w; wr_data = d; cmd_code = c; cmd_addr = a; dbg_mode = g;
    #5;
    compare();
    @(posedge clk);
    if (w) begin
      if (g) begin
        m_open = int'(d[7]); m_off = int'(d[3]); m_size = int'(d[2:0]);
      end else begin
        if (m_off == 1) m_size = int'(d[2:0]);
        m_open = m_open & int'(d[7]);
        m_off  = m_off & int'(d[3]);
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    #5;
    compare();   // R11: new register already visible at the violation output
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] b);
    rst_n = 1'b0; boot_prot = b; wr_en = 1'b0; dbg_mode = 1'b0;
    #3;
    n_chk++;
    if (prot_q != b) begin
      n_bad++;
      $display("FAIL R1 reset load: actual %02h expected %02h", prot_q, b);
    end
    m_open = int'(b[7]); m_flags = int'(b[6:4]); m_off = int'(b[3]); m_size = int'(b[2:0]);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(8'hFF);
    // R3: everything open
    apply(0, 8'h00, 8'h20, 12'hFFF, 0);
    apply(0, 8'h00, 8'h41, 12'h123, 0);
    // per-size boundary sweep
    for (int n = 0; n < 8; n++) begin
      int lo;
      logic [2:0] s;
      lo = 4096 - 64 * (n + 1);
      s = 3'(n);
      do_reset({1'b1, 3'(7 - n), 1'b1, 3'(n ^ 5)});
      apply(1, {5'b11111, s} | 8'h08, 8'h05, 12'hFFF, 0);   // R6 size loads while range off
      apply(1, {5'b10000, s}, 8'h20, 12'(lo), 0);          // R5 clear range-off
      apply(0, 8'h00, 8'h20, 12'(lo - 1), 0);              // R4 below floor
      apply(0, 8'h00, 8'h20, 12'(lo), 0);                  // R4 at floor
      apply(0, 8'h00, 8'h40, 12'(lo + 2), 0);
      apply(0, 8'h00, 8'h60, 12'(lo - 1), 0);
      apply(0, 8'h00, 8'h05, 12'(lo), 0);                  // R10
      apply(1, 8'hFF ^ {5'b0, s}, 8'h41, 12'h000, 0);      // R5 R6 R7 ignored writes, R9
      apply(0, 8'h00, 8'h20, 12'(lo - 1), 0);
      apply(1, 8'h7F, 8'h20, 12'h000, 0);                  // R2 close array
      apply(0, 8'h00, 8'h60, 12'h000, 0);
      apply(1, {4'h8, 1'b1, s}, 8'h41, 12'h000, 1);        // R8 debug reopen
      apply(0, 8'h00, 8'h41, 12'h000, 0);                  // R9 fully open
    end
    // randomized phase
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] c;
      int a;
      case ($urandom_range(0, 5))
        0: c = 8'h05; 1: c = 8'h20; 2: c = 8'h40;
        3: c = 8'h41; 4: c = 8'h60; default: c = 8'($urandom);
      endcase
      if ($urandom_range(0, 1) == 1)
        a = (4096 - 64 * int'($urandom_range(1, 8)) + int'($urandom_range(0, 4)) - 2) & 'hFFF;
      else
        a = int'($urandom_range(0, 4095));
      if ($urandom_range(0, 199) == 0) do_reset(8'($urandom));
      apply(1'($urandom_range(0, 3) == 0), 8'($urandom | 32'h88), c, 12'(a),
            1'($urandom_range(0, 15) == 0));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule